// File: doc/BRIEF.md
# GPIO Atomic Set/Clear/Toggle Register Block

This block keeps the output-drive state for two banks of general-purpose pins: a main bank and a secondary bank that serves the flash-interface pins. Each bank has a 30-bit output value register and a 30-bit output-enable register. Software reaches each register through four word addresses. The plain address loads the register. The other three set, clear or toggle only the bits selected by the write data. A single store can therefore change some pins without a read-modify-write sequence that could race with another agent.

The block sits on a simple 32-bit register bus. The bus carries an address, a write strobe, write data and combinational read data, with no wait states. The block drives the four register values out as pin vectors. It also reports a resolved 2-bit state for every main-bank pin: driven high, driven low or input. An identifier word and two input-value words are readable and return zero. Undecoded addresses read as all ones.

Top module: `gpio_atomic_regs`

## Requirements
- R1: While `rst_n` is low, all four registers are zero, every pin state is input, and a read of any plain register returns 0.
- R2: A write to a plain address stores `wdata & 0x3FFFFFFF`, so bits 31:30 always read back as 0. The plain addresses are 0x010 (main output), 0x020 (main enable), 0x030 (secondary output) and 0x040 (secondary enable).
- R3: A write to plain address + 0x4 ORs the low 30 data bits into that register.
- R4: A write to plain address + 0x8 ANDs that register with the inverse of the data.
- R5: A write to plain address + 0xC inverts the register bits that are set in the low 30 data bits.
- R6: A write takes effect at the rising clock edge of the cycle in which `bus_wr` is high. Read data follows the address combinationally, so a read in the write cycle returns the value held before the write.
- R7: A read of any set, clear or toggle address returns 0.
- R8: Reads of 0x000 (identifier), 0x004 (main input) and 0x008 (secondary input) return 0. Writes to these addresses change nothing.
- R9: A read of any other address returns 0xFFFFFFFF, for example 0x00C, 0x050 or 0x1F0. A write to such an address leaves all four registers unchanged.
- R10: With `bus_wr` low, no register changes, whatever the address and data.
- R11: `main_pin_state[2i+1:2i]` is 2'b00 (input) when main enable bit i is 0. When the enable bit is 1 it is 2'b10 (drive high) if main output bit i is 1, and 2'b01 (drive low) if it is 0.
- R12: Address bits 1:0 are ignored for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data |
| main_out | output | PIN_W (30) | Main bank output values |
| main_oe | output | PIN_W (30) | Main bank output enables |
| aux_out | output | PIN_W (30) | Secondary bank output values |
| aux_oe | output | PIN_W (30) | Secondary bank output enables |
| main_pin_state | output | 2*PIN_W (60) | Resolved state per main-bank pin |

## Verification
A bus write and a bus read of the same register fall in one cycle, because the single address selects both the target of the write and the source of the read data. The bench holds a write to the main output register with the same address and checks two things before the edge: the read data still shows the old contents, and the pin state of the affected pin is unchanged. After the edge it checks that both show the new value. The vector table also chains alias writes on registers whose contents are already known, so a set, clear or toggle that uses stale or wrongly masked data shows up in the read-back.

// File: rtl/gpio_atomic_pkg.sv
`timescale 1ns/1ps
package gpio_atomic_pkg;

  // Alias operation selected by word-address bits [1:0] inside a register group
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TGL  = 2'd3
  } wr_op_e;

  // Resolved per-pin drive state
  typedef enum logic [1:0] {
    PIN_IN   = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10
  } pin_state_e;

  localparam int NUM_REGS     = 4;
  localparam int REG_MAIN_OUT = 0;
  localparam int REG_MAIN_OE  = 1;
  localparam int REG_AUX_OUT  = 2;
  localparam int REG_AUX_OE   = 3;

  // Word indices (byte offset / 4)
  localparam int WIDX_ZERO_LAST = 2;   // identifier and two input words
  localparam int WIDX_REG_FIRST = 4;
  localparam int WIDX_REG_LAST  = 19;

endpackage

// File: rtl/gpio_addr_decode.sv
`timescale 1ns/1ps
module gpio_addr_decode
  import gpio_atomic_pkg::*;
#(
  parameter int WIDX_W = 10
) (
  input  logic [WIDX_W-1:0]   word_idx,
  output logic [NUM_REGS-1:0] reg_hit,
  output wr_op_e              op,
  output logic                zero_rd,
  output logic                undecoded
);

  logic       in_range;
  logic [2:0] grp;

  always_comb begin
    in_range  = (word_idx >= WIDX_W'(WIDX_REG_FIRST)) &&
                (word_idx <= WIDX_W'(WIDX_REG_LAST));
    grp       = word_idx[4:2] - 3'd1;
    op        = wr_op_e'(word_idx[1:0]);
    zero_rd   = (word_idx <= WIDX_W'(WIDX_ZERO_LAST));
    undecoded = !in_range && !zero_rd;
    for (int g = 0; g < NUM_REGS; g++) begin
      reg_hit[g] = in_range && (grp == 3'(g));
    end
  end

endmodule

// File: rtl/gpio_alias_reg.sv
`timescale 1ns/1ps
module gpio_alias_reg
  import gpio_atomic_pkg::*;
#(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         wr,
  input  wr_op_e       op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic         en;
  logic [W-1:0] q_nxt;

  // next-state
  always_comb begin
    en = hit && wr;
    unique case (op)
      OP_LOAD: q_nxt = wdata;
      OP_SET:  q_nxt = q | wdata;
      OP_CLR:  q_nxt = q & ~wdata;
      OP_TGL:  q_nxt = q ^ wdata;
      default: q_nxt = q;
    endcase
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/gpio_pin_resolve.sv
`timescale 1ns/1ps
module gpio_pin_resolve
  import gpio_atomic_pkg::*;
#(
  parameter int PIN_W = 30
) (
  input  logic [PIN_W-1:0]   out_val,
  input  logic [PIN_W-1:0]   out_en,
  output logic [2*PIN_W-1:0] state
);

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign state[2*i +: 2] = out_en[i] ? (out_val[i] ? PIN_HIGH : PIN_LOW) : PIN_IN;
  end

endmodule

// File: rtl/gpio_atomic_regs.sv
`timescale 1ns/1ps
module gpio_atomic_regs
  import gpio_atomic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PIN_W  = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [PIN_W-1:0]    main_out,
  output logic [PIN_W-1:0]    main_oe,
  output logic [PIN_W-1:0]    aux_out,
  output logic [PIN_W-1:0]    aux_oe,
  output logic [2*PIN_W-1:0]  main_pin_state
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]   word_idx;
  logic [NUM_REGS-1:0] reg_hit;
  wr_op_e              op;
  logic                zero_rd;
  logic                undecoded;
  logic [PIN_W-1:0]    wdata_pins;
  logic [PIN_W-1:0]    reg_q [NUM_REGS];
  logic                unused_bits;

  assign word_idx    = bus_addr[ADDR_W-1:2];
  assign wdata_pins  = bus_wdata[PIN_W-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:PIN_W]};

  gpio_addr_decode #(.WIDX_W(WIDX_W)) dec_i (
    .word_idx  (word_idx),
    .reg_hit   (reg_hit),
    .op        (op),
    .zero_rd   (zero_rd),
    .undecoded (undecoded)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    gpio_alias_reg #(.W(PIN_W)) reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (reg_hit[g]),
      .wr    (bus_wr),
      .op    (op),
      .wdata (wdata_pins),
      .q     (reg_q[g])
    );
  end

  // read mux: plain words return contents, aliases return zero
  always_comb begin
    bus_rdata = '0;
    if (undecoded) begin
      bus_rdata = '1;
    end else if (!zero_rd) begin
      for (int g = 0; g < NUM_REGS; g++) begin
        if (reg_hit[g] && op == OP_LOAD) begin
          bus_rdata = DATA_W'(reg_q[g]);
        end
      end
    end
  end

  assign main_out = reg_q[REG_MAIN_OUT];
  assign main_oe  = reg_q[REG_MAIN_OE];
  assign aux_out  = reg_q[REG_AUX_OUT];
  assign aux_oe   = reg_q[REG_AUX_OE];

  gpio_pin_resolve #(.PIN_W(PIN_W)) res_i (
    .out_val (main_out),
    .out_en  (main_oe),
    .state   (main_pin_state)
  );

endmodule

// File: rtl/gpio_atomic_regs_chk.sv
`timescale 1ns/1ps
module gpio_atomic_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PIN_W  = 30
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [PIN_W-1:0]   main_out,
  input logic [PIN_W-1:0]   main_oe,
  input logic [PIN_W-1:0]   aux_out,
  input logic [PIN_W-1:0]   aux_oe,
  input logic [2*PIN_W-1:0] main_pin_state
);

  logic [ADDR_W-3:0] wi;
  logic [PIN_W-1:0]  wd;
  logic              unused_chk;
  assign wi         = bus_addr[ADDR_W-1:2];
  assign wd         = bus_wdata[PIN_W-1:0];
  assign unused_chk = ^{bus_addr[1:0], bus_wdata[DATA_W-1:PIN_W]};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (main_out == '0 && main_oe == '0 && aux_out == '0 && aux_oe == '0));

  // R2
  load_main_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wi == 4) |=> main_out == $past(wd));

  // R3
  set_main_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wi == 9) |=> main_oe == $past(main_oe | wd));

  // R4
  clr_aux_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wi == 14) |=> aux_out == $past(aux_out & ~wd));

  // R5
  tgl_aux_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wi == 19) |=> aux_oe == $past(aux_oe ^ wd));

  // R7
  alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wi >= 4 && wi <= 19 && wi[1:0] != 2'd0) |-> bus_rdata == '0);

  // R9
  undecoded_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wi == 3 || wi > 19) |-> bus_rdata == '1);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(main_out) && $stable(main_oe) && $stable(aux_out) && $stable(aux_oe)));

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    // R11
    pin_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      main_pin_state[2*p +: 2] == (main_oe[p] ? (main_out[p] ? 2'b10 : 2'b01) : 2'b00));
  end

endmodule

bind gpio_atomic_regs gpio_atomic_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_W(PIN_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_addr       (bus_addr),
  .bus_wr         (bus_wr),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .main_out       (main_out),
  .main_oe        (main_oe),
  .aux_out        (aux_out),
  .aux_oe         (aux_oe),
  .main_pin_state (main_pin_state)
);

// File: tb/gpio_atomic_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_atomic_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [29:0] main_out, main_oe, aux_out, aux_oe;
  logic [59:0] main_pin_state;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  gpio_atomic_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .main_out(main_out),
    .main_oe(main_oe), .aux_out(aux_out), .aux_oe(aux_oe),
    .main_pin_state(main_pin_state)
  );

  typedef struct packed {
    logic [11:0] waddr;
    logic [31:0] wdata;
    logic [11:0] raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // write waddr/wdata, then read raddr after the edge
  localparam vec_t VEC [22] = '{
    '{12'h010, 32'hFFFF_FFFF, 12'h010, 32'h3FFF_FFFF, 4'd2},   // R2 mask
    '{12'h018, 32'h0000_FFFF, 12'h010, 32'h3FFF_0000, 4'd4},   // R4
    '{12'h014, 32'hC000_0003, 12'h010, 32'h3FFF_0003, 4'd3},   // R3
    '{12'h01C, 32'hF000_00FF, 12'h010, 32'h0FFF_00FC, 4'd5},   // R5
    '{12'h020, 32'h1234_5678, 12'h020, 32'h1234_5678, 4'd2},   // R2
    '{12'h024, 32'h0000_0F00, 12'h020, 32'h1234_5F78, 4'd3},   // R3
    '{12'h028, 32'h1000_0008, 12'h020, 32'h0234_5F70, 4'd4},   // R4
    '{12'h02C, 32'hFFFF_FFFF, 12'h020, 32'h3DCB_A08F, 4'd5},   // R5
    '{12'h030, 32'hAAAA_AAAA, 12'h030, 32'h2AAA_AAAA, 4'd2},   // R2
    '{12'h03C, 32'h0000_000F, 12'h030, 32'h2AAA_AAA5, 4'd5},   // R5
    '{12'h044, 32'h0000_0011, 12'h040, 32'h0000_0011, 4'd3},   // R3
    '{12'h048, 32'h0000_0001, 12'h040, 32'h0000_0010, 4'd4},   // R4
    '{12'h034, 32'hFFFF_FFFF, 12'h034, 32'h0000_0000, 4'd7},   // R7
    '{12'h038, 32'hFFFF_FFFF, 12'h030, 32'h0000_0000, 4'd4},   // R4
    '{12'h00C, 32'hFFFF_FFFF, 12'h010, 32'h0FFF_00FC, 4'd9},   // R9
    '{12'h000, 32'hFFFF_FFFF, 12'h000, 32'h0000_0000, 4'd8},   // R8
    '{12'h004, 32'hFFFF_FFFF, 12'h004, 32'h0000_0000, 4'd8},   // R8
    '{12'h008, 32'hFFFF_FFFF, 12'h008, 32'h0000_0000, 4'd8},   // R8
    '{12'h050, 32'h0000_0001, 12'h050, 32'hFFFF_FFFF, 4'd9},   // R9
    '{12'h013, 32'h0000_0005, 12'h011, 32'h0000_0005, 4'd12},  // R12
    '{12'h1F0, 32'h0000_0000, 12'h020, 32'h3DCB_A08F, 4'd9},   // R9
    '{12'h0FC, 32'h0000_0000, 12'h02C, 32'h0000_0000, 4'd7}    // R7
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_addr = 12'h020;
    #1;
    check("R1 regs", {main_out, main_oe, aux_out, aux_oe}, '0);
    check("R1 pin_state", main_pin_state, 60'd0);
    check("R1 read", bus_rdata, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 22; i++) begin
      @(negedge clk);
      bus_addr = VEC[i].waddr; bus_wdata = VEC[i].wdata; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = VEC[i].raddr;
      #1;
      check($sformatf("R%0d vec%0d", VEC[i].req, i), bus_rdata, VEC[i].exp);
    end

    // R11 pin states: main_out=5 now, set enable = 3
    @(negedge clk);
    bus_addr = 12'h020; bus_wdata = 32'h3; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    check("R11 pins0-2", main_pin_state[5:0], 64'h06);
    check("R11 port out", main_out, 30'h5);

    // R6 write and read of the same register in one cycle
    @(negedge clk);
    bus_addr = 12'h010; bus_wdata = 32'h0; bus_wr = 1'b1;
    #1;
    check("R6 old read", bus_rdata, 32'h5);
    check("R6 old pin", main_pin_state[1:0], 2'b10);
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    check("R6 new read", bus_rdata, 32'h0);
    check("R6 new pin", main_pin_state[1:0], 2'b01);

    // R10 no strobe, no change
    @(negedge clk);
    bus_addr = 12'h010; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b0;
    @(negedge clk);
    #1;
    check("R10 hold", bus_rdata, 32'h0);
    check("R10 oe", main_oe, 30'h3);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0; bus_addr = 12'h020;
    #1;
    check("R1 midrun regs", {main_out, main_oe, aux_out, aux_oe}, '0);
    check("R1 midrun read", bus_rdata, 32'h0);
    check("R1 midrun pins", main_pin_state, 60'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    summary();
  end

endmodule